// File: doc/BRIEF.md
# Paged-Mode SDRAM Controller

This block sits between a simple word-wide request port and one bank of synchronous DRAM. A request carries a write flag, a word address and, for writes, a data word. The controller splits the address into a row part and a column part. It sends the row first, with an activate command, and the column afterwards, with a read or write command. Both travel over the same set of address pins.

Once a row has been activated it stays open. Later requests that fall in the same row need only a column command, which is what makes a streak of nearby accesses cheap. A request to a different row first closes the open row with a precharge and then opens the new one.

All device timing is set by parameters counted in clock cycles: CAS latency, activate-to-column delay, precharge time, minimum row-active time, the wake delay after chip select, and the refresh duration. A free-running interval counter raises a refresh demand. That demand waits for any access in flight to finish, closes the open row, issues a refresh, and holds new requests off until the refresh is complete. Read data comes back as a one-cycle valid pulse.

Top module: `sdram_page_ctrl`

## Requirements
- R1: The upper ROW_W bits of `req_addr` select the row and the lower COL_W bits select the column. An activate drives the row on `sd_addr`. A read or write drives the column, zero-extended, on the same `sd_addr` pins.
- R2: A read or write command is issued no sooner than T_RCD cycles after the activate that opened its row.
- R3: For a read command in cycle c, `rd_valid` is high for one cycle, in cycle c+T_CL+1. In that cycle `rd_data` holds the value `sd_dq_in` had during cycle c+T_CL. Read results return in request order.
- R4: An activate or refresh comes at least T_RP cycles after the last precharge. No command comes sooner than T_RFC cycles after a refresh.
- R5: A precharge comes at least T_RAS cycles after the last activate.
- R6: During reset the command pins read deselect (1111), and `req_ready`, `rd_valid` and `sd_dq_oe` are low. The first cycle with `sd_cs_n` low carries a no-op. Any other command comes at least T_CMD cycles after that cycle. A precharge and then a refresh are issued before the first activate.
- R7: A request to the open row is served by a column command alone, with no activate or precharge in between. A request to another row first gets a precharge and then an activate of the new row.
- R8: A refresh is issued only while no row is open. Two refresh commands are never more than T_REFI + T_RAS + T_CL + T_RP + T_RFC + 8 cycles apart. A due refresh is served before any new request.
- R9: In a write command cycle, `sd_dq_oe` is 1 and `sd_dq_out` holds the request's write data. In every other cycle `sd_dq_oe` is 0. It is never 1 in a cycle where read data is returning on `sd_dq_in`.
- R10: Each handshake (`req_valid` and `req_ready` both high) produces exactly one column command of the matching type in the next cycle, in request order.
- R11: Commands are encoded on {`sd_cs_n`,`sd_ras_n`,`sd_cas_n`,`sd_we_n`} as follows: 0111 no-op, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0001 refresh, 1111 deselect. No other value appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | max(ROW_W,COL_W) | Shared row/column address |
| sd_dq_out | output | DATA_W | Data driven to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | DATA_W | Data from the device |

## Verification
The collision of interest is a refresh falling due while a page-hit stream is running or while read data is still coming back. Short refresh intervals combined with back-to-back same-row traffic make this happen many times, both in directed streaks and in a long mixed stream with random gaps. The reference model records every command on the pins. It checks that every refresh lands on a closed row within the allowed delay. It checks that no column command slips in between the refresh demand and the refresh completing. It checks that the delayed requests are still served in order with the right data.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // Pin encoding {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP   = 4'b0111,
    CMD_ACT   = 4'b0011,
    CMD_RD    = 4'b0101,
    CMD_WR    = 4'b0100,
    CMD_PRE   = 4'b0010,
    CMD_REF   = 4'b0001,
    CMD_DESEL = 4'b1111
  } sd_cmd_e;

  typedef enum logic [1:0] {
    ST_WAKE,
    ST_INIT_PRE,
    ST_INIT_REF,
    ST_RUN
  } ctl_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdc_gap_timer.sv
// Down-counter: a load of N-1 makes `expired` true again N cycles after the
// event whose decision performed the load.
module sdc_gap_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdc_refresh_timer.sv
// Free-running interval counter; raises `due` once per interval, held until served.
module sdc_refresh_timer #(
  parameter int T_REFI = 780
) (
  input  logic clk,
  input  logic rst_n,
  input  logic served,
  output logic due
);

  localparam int W = (T_REFI > 1) ? $clog2(T_REFI) : 1;

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic         due_q;
  logic         due_d;
  logic         wrap;

  assign wrap = (cnt_q == W'(T_REFI - 1));

  always_comb begin
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
    due_d = due_q;
    if (wrap) begin
      due_d = 1'b1;
    end else if (served) begin
      due_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      due_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      due_q <= due_d;
    end
  end

  assign due = due_q;

endmodule

// File: rtl/sdc_read_return.sv
// Tracks reads in flight and captures device data CL cycles after the command.
module sdc_read_return #(
  parameter int T_CL   = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic [DATA_W-1:0] dq_in,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic [T_CL:0]     pipe_q;
  logic [T_CL:0]     pipe_d;
  logic              vld_q;
  logic [DATA_W-1:0] data_q;

  assign pipe_d = {pipe_q[T_CL-1:0], rd_issue};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= '0;
      vld_q  <= 1'b0;
      data_q <= '0;
    end else begin
      pipe_q <= pipe_d;
      vld_q  <= pipe_q[T_CL];
      if (pipe_q[T_CL]) begin
        data_q <= dq_in;
      end
    end
  end

  assign busy     = |pipe_q;
  assign rd_valid = vld_q;
  assign rd_data  = data_q;

endmodule

// File: rtl/sdram_page_ctrl.sv
module sdram_page_ctrl
  import sdc_pkg::*;
#(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int T_CL   = 2,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_RAS  = 6,
  parameter int T_CMD  = 1,
  parameter int T_RFC  = 4,
  parameter int T_REFI = 780,
  localparam int SA_W   = max_of(ROW_W, COL_W),
  localparam int ADDR_W = ROW_W + COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [SA_W-1:0]   sd_addr,
  output logic [DATA_W-1:0] sd_dq_out,
  output logic              sd_dq_oe,
  input  logic [DATA_W-1:0] sd_dq_in
);

  localparam int T_MAX = max_of(max_of(max_of(T_RCD, T_RAS), max_of(T_RP, T_RFC)), T_CMD);
  localparam int CNT_W = $clog2(T_MAX + 1);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  // state
  ctl_state_e        state_q, state_d;
  sd_cmd_e           cmd_q, cmd_d;
  logic              open_q, open_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic [SA_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic              oe_q, oe_d;

  // timers and helpers
  logic             rcd_ok, ras_ok, quiet_ok;
  logic             act_load, quiet_load;
  logic [CNT_W-1:0] quiet_val;
  logic             ref_due, ref_served;
  logic             rd_busy;

  logic [ROW_W-1:0] req_row;
  logic [COL_W-1:0] req_col;
  logic             row_hit;
  logic             col_ok;
  logic             close_ok;

  assign req_row  = req_addr[ADDR_W-1:COL_W];
  assign req_col  = req_addr[COL_W-1:0];
  assign row_hit  = open_q && (row_q == req_row);
  assign col_ok   = rcd_ok && !(req_write && rd_busy);
  assign close_ok = ras_ok && !rd_busy;

  always_comb begin
    state_d    = state_q;
    cmd_d      = CMD_NOP;
    open_d     = open_q;
    row_d      = row_q;
    addr_d     = addr_q;
    act_load   = 1'b0;
    quiet_load = 1'b0;
    quiet_val  = '0;
    ref_served = 1'b0;
    req_ready  = 1'b0;

    unique case (state_q)
      ST_WAKE: begin
        quiet_load = 1'b1;
        quiet_val  = CNT_W'(T_CMD - 1);
        state_d    = ST_INIT_PRE;
      end
      ST_INIT_PRE: begin
        if (quiet_ok) begin
          cmd_d      = CMD_PRE;
          addr_d     = '0;
          quiet_load = 1'b1;
          quiet_val  = CNT_W'(T_RP - 1);
          state_d    = ST_INIT_REF;
        end
      end
      ST_INIT_REF: begin
        if (quiet_ok) begin
          cmd_d      = CMD_REF;
          quiet_load = 1'b1;
          quiet_val  = CNT_W'(T_RFC - 1);
          state_d    = ST_RUN;
        end
      end
      default: begin
        if (ref_due) begin
          if (open_q) begin
            if (close_ok) begin
              cmd_d      = CMD_PRE;
              addr_d     = '0;
              open_d     = 1'b0;
              quiet_load = 1'b1;
              quiet_val  = CNT_W'(T_RP - 1);
            end
          end else if (quiet_ok) begin
            cmd_d      = CMD_REF;
            quiet_load = 1'b1;
            quiet_val  = CNT_W'(T_RFC - 1);
            ref_served = 1'b1;
          end
        end else if (req_valid) begin
          if (row_hit) begin
            if (col_ok) begin
              cmd_d     = req_write ? CMD_WR : CMD_RD;
              addr_d    = SA_W'(req_col);
              req_ready = 1'b1;
            end
          end else if (open_q) begin
            if (close_ok) begin
              cmd_d      = CMD_PRE;
              addr_d     = '0;
              open_d     = 1'b0;
              quiet_load = 1'b1;
              quiet_val  = CNT_W'(T_RP - 1);
            end
          end else if (quiet_ok) begin
            cmd_d    = CMD_ACT;
            addr_d   = SA_W'(req_row);
            open_d   = 1'b1;
            row_d    = req_row;
            act_load = 1'b1;
          end
        end
      end
    endcase
  end

  assign oe_d = (cmd_d == CMD_WR);
  assign dq_d = oe_d ? req_wdata : dq_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_WAKE;
      cmd_q   <= CMD_DESEL;
      open_q  <= 1'b0;
      row_q   <= '0;
      addr_q  <= '0;
      dq_q    <= '0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      open_q  <= open_d;
      row_q   <= row_d;
      addr_q  <= addr_d;
      dq_q    <= dq_d;
      oe_q    <= oe_d;
    end
  end

  sdc_gap_timer #(.CNT_W(CNT_W)) u_rcd (
    .clk(clk), .rst_n(rst_int_n), .load(act_load),
    .load_val(CNT_W'(T_RCD - 1)), .expired(rcd_ok)
  );

  sdc_gap_timer #(.CNT_W(CNT_W)) u_ras (
    .clk(clk), .rst_n(rst_int_n), .load(act_load),
    .load_val(CNT_W'(T_RAS - 1)), .expired(ras_ok)
  );

  sdc_gap_timer #(.CNT_W(CNT_W)) u_quiet (
    .clk(clk), .rst_n(rst_int_n), .load(quiet_load),
    .load_val(quiet_val), .expired(quiet_ok)
  );

  sdc_refresh_timer #(.T_REFI(T_REFI)) u_refi (
    .clk(clk), .rst_n(rst_int_n), .served(ref_served), .due(ref_due)
  );

  sdc_read_return #(.T_CL(T_CL), .DATA_W(DATA_W)) u_rret (
    .clk(clk), .rst_n(rst_int_n), .rd_issue(cmd_d == CMD_RD),
    .dq_in(sd_dq_in), .busy(rd_busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;
  assign sd_addr   = addr_q;
  assign sd_dq_out = dq_q;
  assign sd_dq_oe  = oe_q;

endmodule

// File: rtl/sdc_checker.sv
module sdc_checker #(
  parameter int T_RCD = 3,
  parameter int T_RP  = 2,
  parameter int T_RAS = 6,
  parameter int T_CMD = 1,
  parameter int T_RFC = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       dq_oe,
  input logic       req_valid,
  input logic       req_ready
);

  localparam int SAT = 1024;

  int   since_act, since_pre, since_ref, since_cs;
  logic cs_seen, open_t;
  logic is_act, is_pre, is_ref, is_col, is_wr, is_real;

  assign is_act  = (cmd == 4'b0011);
  assign is_pre  = (cmd == 4'b0010);
  assign is_ref  = (cmd == 4'b0001);
  assign is_wr   = (cmd == 4'b0100);
  assign is_col  = is_wr || (cmd == 4'b0101);
  assign is_real = !cmd[3] && (cmd != 4'b0111);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_pre <= SAT;
      since_ref <= SAT;
      since_cs  <= 0;
      cs_seen   <= 1'b0;
      open_t    <= 1'b0;
    end else begin
      since_act <= is_act ? 1 : ((since_act < SAT) ? since_act + 1 : SAT);
      since_pre <= is_pre ? 1 : ((since_pre < SAT) ? since_pre + 1 : SAT);
      since_ref <= is_ref ? 1 : ((since_ref < SAT) ? since_ref + 1 : SAT);
      if (!cs_seen && !cmd[3]) begin
        cs_seen  <= 1'b1;
        since_cs <= 1;
      end else if (cs_seen && since_cs < SAT) begin
        since_cs <= since_cs + 1;
      end
      if (is_act) open_t <= 1'b1;
      else if (is_pre) open_t <= 1'b0;
    end
  end

  // R2
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> since_act >= T_RCD);

  // R4
  rp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_act || is_ref) |-> since_pre >= T_RP);

  // R4
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_real |-> since_ref >= T_RFC);

  // R5
  ras_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_pre |-> since_act >= T_RAS);

  // R6
  wake_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_real |-> (cs_seen && since_cs >= T_CMD));

  // R7
  col_open_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_col || is_act) |-> (open_t == is_col));

  // R8
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> !open_t);

  // R9
  oe_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> is_wr);

  // R10
  accept_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> is_col);

endmodule

bind sdram_page_ctrl sdc_checker #(
  .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_CMD(T_CMD), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rst_n(rst_n),
  .cmd({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .dq_oe(sd_dq_oe), .req_valid(req_valid), .req_ready(req_ready)
);

// File: tb/sim_sdram_page_ctrl.sv
`timescale 1ns/1ps
module sim_sdram_page_ctrl;

  localparam int ROW_W = 8, COL_W = 6, DW = 16;
  localparam int CL = 2, RCD = 3, RP = 2, RAS = 6, TCMD = 1, RFC = 4, REFI = 60;
  localparam int SA_W = 8, AW = ROW_W + COL_W;
  localparam int SLACK = RAS + CL + RP + RFC + 8;

  localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                         C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001,
                         C_DES = 4'b1111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DW-1:0] rd_data, sd_dq_out;
  logic [DW-1:0] sd_dq_in = 16'hDEAD;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [SA_W-1:0] sd_addr;

  always #2 clk = ~clk;

  sdram_page_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_CL(CL), .T_RCD(RCD),
    .T_RP(RP), .T_RAS(RAS), .T_CMD(TCMD), .T_RFC(RFC), .T_REFI(REFI)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
    .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_addr(sd_addr),
    .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] fill(input int a);
    return DW'((a * 37) ^ 16'h5A3C);
  endfunction

  // reference model state
  logic [DW-1:0] mem[int];
  int q_cyc[$], q_addr[$];
  bit q_wr[$];
  logic [DW-1:0] q_data[$];
  int exp_cyc[$];
  logic [DW-1:0] exp_data[$];
  int drv_cyc[$];
  logic [DW-1:0] drv_data[$];
  int first_cs = -1, last_act = -10000, last_pre = -10000, last_ref = -10000;
  bit open = 0, saw_init_pre = 0, saw_init_ref = 0;
  int orow = 0, acts = 0, refs = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    logic [3:0] c;
    int t, a;
    logic [DW-1:0] v;
    t = cyc;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (rst_n) begin
      // R11: legal encodings only
      if (!(c inside {C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_DES}))
        chk(0, "R11", "illegal command code", c, C_NOP);
      if (!c[3] && first_cs < 0) begin
        first_cs = t;
        chk(c == C_NOP, "R6", "first selected cycle is no-op", c, C_NOP);
      end
      if (c[3] && first_cs >= 0) chk(0, "R6", "chip deselected after wake", c, C_NOP);
      if (c != C_NOP && !c[3]) chk(t - first_cs >= TCMD, "R6", "wake delay", t - first_cs, TCMD);
      if (c != C_NOP && !c[3] && c != C_PRE)
        chk(t - last_ref >= RFC, "R4", "refresh duration", t - last_ref, RFC);

      if (c == C_ACT) begin
        chk(saw_init_pre && saw_init_ref, "R6", "init precharge+refresh before activate", 0, 1);
        chk(t - last_pre >= RP, "R4", "precharge to activate", t - last_pre, RP);
        chk(!open, "R7", "activate with row open", open, 0);
        open = 1; orow = int'(sd_addr); last_act = t; acts++;
      end
      if (c == C_PRE) begin
        chk(t - last_act >= RAS, "R5", "activate to precharge", t - last_act, RAS);
        open = 0; last_pre = t; saw_init_pre = 1;
      end
      if (c == C_REF) begin
        chk(saw_init_pre, "R6", "precharge before first refresh", 0, 1);
        chk(!open, "R8", "refresh with row open", open, 0);
        chk(t - last_pre >= RP, "R4", "precharge to refresh", t - last_pre, RP);
        if (refs > 0) chk(t - last_ref <= REFI + SLACK, "R8", "refresh gap", t - last_ref, REFI + SLACK);
        last_ref = t; refs++; saw_init_ref = 1;
      end
      if (c == C_RD || c == C_WR) begin
        if (q_cyc.size() == 0) begin
          chk(0, "R10", "column command without request", c, C_NOP);
        end else begin
          chk(q_cyc[0] == t - 1, "R10", "column one cycle after accept", t, q_cyc[0] + 1);
          chk((c == C_WR) == q_wr[0], "R10", "command type", c, q_wr[0] ? C_WR : C_RD);
          a = q_addr[0];
          chk(open && orow == (a >> COL_W), "R7", "column on open matching row", orow, a >> COL_W);
          chk(int'(sd_addr) == (a % (1 << COL_W)), "R1", "column on shared pins", sd_addr, a % (1 << COL_W));
          chk(t - last_act >= RCD, "R2", "activate to column", t - last_act, RCD);
          if (c == C_WR) begin
            chk(sd_dq_oe && sd_dq_out == q_data[0], "R9", "write data on bus", sd_dq_out, q_data[0]);
            mem[a] = q_data[0];
          end else begin
            v = mem.exists(a) ? mem[a] : fill(a);
            exp_cyc.push_back(t + CL + 1); exp_data.push_back(v);
            drv_cyc.push_back(t + CL); drv_data.push_back(v);
          end
          void'(q_cyc.pop_front()); void'(q_addr.pop_front());
          void'(q_wr.pop_front()); void'(q_data.pop_front());
        end
      end else if (sd_dq_oe) begin
        chk(0, "R9", "output enable outside write", sd_dq_oe, 0);
      end
      if (q_cyc.size() > 0 && q_cyc[0] < t - 1) begin
        chk(0, "R10", "accepted request never issued", t, q_cyc[0] + 1);
        void'(q_cyc.pop_front()); void'(q_addr.pop_front());
        void'(q_wr.pop_front()); void'(q_data.pop_front());
      end
      // device model drives read data
      if (drv_cyc.size() > 0 && drv_cyc[0] == t) begin
        sd_dq_in = drv_data[0];
        chk(!sd_dq_oe, "R9", "bus contention with read return", sd_dq_oe, 0);
        void'(drv_cyc.pop_front()); void'(drv_data.pop_front());
      end
      // read return
      if (rd_valid) begin
        if (exp_cyc.size() == 0) chk(0, "R3", "unexpected read valid", 1, 0);
        else begin
          chk(exp_cyc[0] == t, "R3", "read latency", t, exp_cyc[0]);
          chk(rd_data == exp_data[0], "R3", "read data", rd_data, exp_data[0]);
          void'(exp_cyc.pop_front()); void'(exp_data.pop_front());
        end
      end else if (exp_cyc.size() > 0 && exp_cyc[0] <= t) begin
        chk(0, "R3", "missing read valid", 0, 1);
        void'(exp_cyc.pop_front()); void'(exp_data.pop_front());
      end
      // record accepted request
      if (req_valid && req_ready) begin
        q_cyc.push_back(t); q_addr.push_back(int'(req_addr));
        q_wr.push_back(req_write); q_data.push_back(req_wdata);
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #0.5;
  endtask

  task automatic send(input bit wr, input int row, input int col, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr;
    req_addr = {row[ROW_W-1:0], col[COL_W-1:0]}; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #0.5;
    req_valid = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    int a0, r0;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_DES, "R6", "reset command pins",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_DES);
    chk(!req_ready && !rd_valid && !sd_dq_oe, "R6", "reset outputs low",
        {req_ready, rd_valid, sd_dq_oe}, 0);
    @(posedge clk); #0.5;
    rst_n = 1'b1;
    idle(12);

    // R7: page-hit streak
    a0 = acts; r0 = refs;
    for (int i = 0; i < 8; i++) send(1, 5, i, 16'h1000 + 16'(i));
    for (int i = 0; i < 8; i++) send(0, 5, i, '0);
    idle(10);
    chk(acts - a0 <= 1 + (refs - r0), "R7", "activates in same-row streak", acts - a0, 1 + refs - r0);

    // R1/R7: row misses and address boundaries
    send(1, 9, 3, 16'hBEEF);
    send(0, 5, 2, '0);
    send(0, 9, 3, '0);
    send(1, 255, 63, 16'hF00D);
    send(0, 255, 63, '0);
    send(1, 0, 0, 16'h0001);
    send(0, 0, 0, '0);
    // never-written location
    send(0, 17, 1, '0);
    // R9: write right behind a read on the same row
    send(0, 5, 1, '0);
    send(1, 5, 1, 16'h7777);
    send(0, 5, 1, '0);
    // R8: idle refreshes
    idle(200);

    // mixed stream with refresh collisions
    for (int i = 0; i < 300; i++) begin
      int r, cidx;
      r = ($urandom % 5 == 0) ? 250 : int'($urandom % 3);
      cidx = int'($urandom % 64);
      send($urandom % 2 == 1, r, cidx, 16'($urandom));
      if ($urandom % 4 == 0) idle(int'($urandom % 3));
    end
    idle(40);
    chk(q_cyc.size() == 0, "R10", "accepted requests outstanding", q_cyc.size(), 0);
    chk(exp_cyc.size() == 0, "R3", "reads outstanding", exp_cyc.size(), 0);
    chk(refs >= cyc / (REFI + SLACK), "R8", "refresh count", refs, cyc / (REFI + SLACK));
    summary();
  end

endmodule